// File: doc/BRIEF.md
# Programmable Output Raster Timing Generator

This block produces the output raster of a line-doubled display. A horizontal pixel counter and a vertical line counter run in the output clock domain. Both are referenced to the leading edges of the incoming horizontal and vertical syncs. Programmable start and end points on these counters form four windows on each axis: sync, blanking, capture and border. The windows are combined into the output syncs, a blanking strobe, a data-enable strobe and a border flag that carries a 24-bit fill colour.

The horizontal total is a programmable 11-bit value with 2-pixel resolution. A mode bit can replace it with a fixed built-in total. The vertical total is never programmed. The block measures it by counting line starts between input vertical sync edges. The counters and the measured total are exported for downstream line-buffer and interpolation logic.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the following outputs go to zero: `h_count`, `v_count`, `v_total`, `out_blank`, `out_de`, `out_border` and `out_border_rgb`. `out_hsync` and `out_vsync` go to their inactive levels, which are `~out_hs_pol` and `~out_vs_pol`.
- R2: `h_count` rises by one every cycle. When no input hsync edge arrives, it returns to 0 in the cycle after it shows the effective total minus 1.
- R3: When `soft_timing` is 1, the effective horizontal total is `{htot_hi, htot_lo, 1'b0}`: `htot_hi` supplies bits 10:3, `htot_lo` supplies bits 2:1, and bit 0 is zero. When `soft_timing` is 0, the total is 780.
- R4: An input hsync leading edge restarts the line. With `in_hs_pol` = 1 the active level is high; with 0 it is low. Let edge k be the first rising clock edge that samples the active level. `h_count` shows 0 after edge k+2, and at edge k+1 it still counts on normally.
- R5: `v_count` advances at each line start and saturates at 1023. An input vsync leading edge (polarity chosen by `in_vs_pol` in the same way as R4) makes the next line start line 0.
- R6: At the line start that follows a vsync edge, `v_total` takes the count of lines since the previous such line start. With vsync edges every L lines, it reads L.
- R7: Each window is set when its counter equals the window's start value. It is cleared when the counter equals its end value, and the end value takes priority. In steady state the window covers counts in [start, end) when start < end. It covers counts ≥ start or < end when start > end, and it is never active when the two are equal.
- R8: `out_hsync` equals the horizontal sync window when `out_hs_pol` = 1 and its inverse when 0. `out_vsync` follows the vertical sync window and `out_vs_pol` in the same way.
- R9: `out_blank` is the OR of the horizontal and vertical blanking windows. `out_de` is high only when both capture windows are active and `out_blank` is low.
- R10: `out_border` is high when `out_blank` and `out_de` are both low and both border windows are active. During border, `out_border_rgb` carries `border_rgb` in software mode and black (0) in hardware mode. It is 0 at all other times.
- R11: All flag outputs refer to the `h_count`/`v_count` values shown in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| in_hs_pol | input | 1 | Input hsync polarity, 1 = active high |
| in_vs_pol | input | 1 | Input vsync polarity, 1 = active high |
| soft_timing | input | 1 | 1 = programmed total and border colour, 0 = built-in defaults |
| htot_hi | input | 8 | Horizontal total bits 10:3 |
| htot_lo | input | 2 | Horizontal total bits 2:1 |
| h_sync_start | input | 11 | Horizontal sync window start |
| h_sync_end | input | 11 | Horizontal sync window end |
| h_blank_start | input | 11 | Horizontal blanking start |
| h_blank_end | input | 11 | Horizontal blanking end |
| h_cap_start | input | 11 | Horizontal capture start |
| h_cap_end | input | 11 | Horizontal capture end |
| h_bord_start | input | 11 | Horizontal border start |
| h_bord_end | input | 11 | Horizontal border end |
| v_sync_start | input | 10 | Vertical sync window start |
| v_sync_end | input | 10 | Vertical sync window end |
| v_blank_start | input | 10 | Vertical blanking start |
| v_blank_end | input | 10 | Vertical blanking end |
| v_cap_start | input | 10 | Vertical capture start |
| v_cap_end | input | 10 | Vertical capture end |
| v_bord_start | input | 10 | Vertical border start |
| v_bord_end | input | 10 | Vertical border end |
| out_hs_pol | input | 1 | Output hsync polarity, 1 = active high |
| out_vs_pol | input | 1 | Output vsync polarity, 1 = active high |
| border_rgb | input | 24 | Border fill colour |
| out_hsync | output | 1 | Output horizontal sync |
| out_vsync | output | 1 | Output vertical sync |
| out_blank | output | 1 | Blanking strobe |
| out_de | output | 1 | Data-enable strobe |
| out_border | output | 1 | Border region flag |
| out_border_rgb | output | 24 | Colour for border pixels, 0 elsewhere |
| h_count | output | 11 | Current pixel in the line |
| v_count | output | 10 | Current line in the frame |
| v_total | output | 11 | Measured lines per frame |

## Verification
The bench targets windows whose start lies past their end, so that they wrap across the line or frame boundary. A set/clear design that did not handle this would leave the window stuck on. It also targets windows with equal start and end, where start priority would keep the window permanently active. The hsync restart is timed to the exact cycle in both input polarities, which exposes an edge detector that reacts to levels or has the polarity inverted. Other cases are a mid-frame switch to the built-in 780-pixel total, where a wrong constant or ignored mode bit shows as a wrong wrap point or a non-black border, and a frame with no vsync. In that frame a counter without saturation would wrap to line 0 and corrupt the vertical windows.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
  // Window slots, one per comparison pair on each axis.
  localparam int WIN_SYNC  = 0;
  localparam int WIN_BLANK = 1;
  localparam int WIN_CAP   = 2;
  localparam int WIN_BORD  = 3;
  localparam int NUM_WIN   = 4;

  // Map an "active" condition onto a pin level for a given polarity bit.
  function automatic logic pin_level(input logic pol, input logic active);
    return pol ? active : ~active;
  endfunction
endpackage

// File: rtl/rtg_edge_detect.sv
`timescale 1ns/1ps
module rtg_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  input  logic pol,
  output logic lead
);
  logic act_s1, act_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_s1 <= 1'b0;
      act_s2 <= 1'b0;
    end else begin
      act_s1 <= pol ? sig : ~sig;
      act_s2 <= act_s1;
    end
  end

  assign lead = act_s1 & ~act_s2;
endmodule

// File: rtl/rtg_window.sv
`timescale 1ns/1ps
module rtg_window #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] first,
  input  logic [W-1:0] last,
  output logic         act_next
);
  logic act_q;

  // End match wins, so start == end yields an empty window.
  always_comb begin
    if (cnt == last)       act_next = 1'b0;
    else if (cnt == first) act_next = 1'b1;
    else                   act_next = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act_next;
  end
endmodule

// File: rtl/rtg_counters.sv
`timescale 1ns/1ps
module rtg_counters #(
  parameter int HW = 11,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_lead,
  input  logic          v_lead,
  input  logic [HW-1:0] htotal,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic [VW:0]   vtotal
);
  logic line_start;
  logic v_pend;
  logic frame_go;

  // >= keeps the counter bounded when the total shrinks mid-line.
  assign line_start = h_lead | (hcnt >= (htotal - 1'b1));
  assign frame_go   = v_pend | v_lead;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
    end else if (line_start) begin
      hcnt <= '0;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_pend <= 1'b0;
    end else if (line_start) begin
      v_pend <= 1'b0;
    end else if (v_lead) begin
      v_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt   <= '0;
      vtotal <= '0;
    end else if (line_start) begin
      if (frame_go) begin
        vtotal <= {1'b0, vcnt} + 1'b1;
        vcnt   <= '0;
      end else if (vcnt != '1) begin
        vcnt <= vcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen #(
  parameter int HW         = 11,
  parameter int VW         = 10,
  parameter int CW         = 24,
  parameter int HDEF_TOTAL = 780
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_hsync,
  input  logic          in_vsync,
  input  logic          in_hs_pol,
  input  logic          in_vs_pol,
  input  logic          soft_timing,
  input  logic [HW-4:0] htot_hi,
  input  logic [1:0]    htot_lo,
  input  logic [HW-1:0] h_sync_start,
  input  logic [HW-1:0] h_sync_end,
  input  logic [HW-1:0] h_blank_start,
  input  logic [HW-1:0] h_blank_end,
  input  logic [HW-1:0] h_cap_start,
  input  logic [HW-1:0] h_cap_end,
  input  logic [HW-1:0] h_bord_start,
  input  logic [HW-1:0] h_bord_end,
  input  logic [VW-1:0] v_sync_start,
  input  logic [VW-1:0] v_sync_end,
  input  logic [VW-1:0] v_blank_start,
  input  logic [VW-1:0] v_blank_end,
  input  logic [VW-1:0] v_cap_start,
  input  logic [VW-1:0] v_cap_end,
  input  logic [VW-1:0] v_bord_start,
  input  logic [VW-1:0] v_bord_end,
  input  logic          out_hs_pol,
  input  logic          out_vs_pol,
  input  logic [CW-1:0] border_rgb,
  output logic          out_hsync,
  output logic          out_vsync,
  output logic          out_blank,
  output logic          out_de,
  output logic          out_border,
  output logic [CW-1:0] out_border_rgb,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic [VW:0]   v_total
);
  import rtg_pkg::*;

  localparam logic [HW-1:0] HDEF = HW'(HDEF_TOTAL);

  logic          h_lead, v_lead;
  logic [HW-1:0] htotal_eff;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  logic [HW-1:0] h_first [NUM_WIN];
  logic [HW-1:0] h_last  [NUM_WIN];
  logic [VW-1:0] v_first [NUM_WIN];
  logic [VW-1:0] v_last  [NUM_WIN];
  logic [NUM_WIN-1:0] h_act, v_act;

  logic blank_n, de_n, bord_n;

  assign htotal_eff = soft_timing ? {htot_hi, htot_lo, 1'b0} : HDEF;

  rtg_edge_detect u_hedge (
    .clk(clk), .rst(rst), .sig(in_hsync), .pol(in_hs_pol), .lead(h_lead)
  );

  rtg_edge_detect u_vedge (
    .clk(clk), .rst(rst), .sig(in_vsync), .pol(in_vs_pol), .lead(v_lead)
  );

  rtg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst(rst), .h_lead(h_lead), .v_lead(v_lead),
    .htotal(htotal_eff), .hcnt(hcnt), .vcnt(vcnt), .vtotal(v_total)
  );

  assign h_first[WIN_SYNC]  = h_sync_start;
  assign h_last [WIN_SYNC]  = h_sync_end;
  assign h_first[WIN_BLANK] = h_blank_start;
  assign h_last [WIN_BLANK] = h_blank_end;
  assign h_first[WIN_CAP]   = h_cap_start;
  assign h_last [WIN_CAP]   = h_cap_end;
  assign h_first[WIN_BORD]  = h_bord_start;
  assign h_last [WIN_BORD]  = h_bord_end;

  assign v_first[WIN_SYNC]  = v_sync_start;
  assign v_last [WIN_SYNC]  = v_sync_end;
  assign v_first[WIN_BLANK] = v_blank_start;
  assign v_last [WIN_BLANK] = v_blank_end;
  assign v_first[WIN_CAP]   = v_cap_start;
  assign v_last [WIN_CAP]   = v_cap_end;
  assign v_first[WIN_BORD]  = v_bord_start;
  assign v_last [WIN_BORD]  = v_bord_end;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    rtg_window #(.W(HW)) u_hwin (
      .clk(clk), .rst(rst), .cnt(hcnt),
      .first(h_first[gi]), .last(h_last[gi]), .act_next(h_act[gi])
    );
    rtg_window #(.W(VW)) u_vwin (
      .clk(clk), .rst(rst), .cnt(vcnt),
      .first(v_first[gi]), .last(v_last[gi]), .act_next(v_act[gi])
    );
  end

  always_comb begin
    blank_n = h_act[WIN_BLANK] | v_act[WIN_BLANK];
    de_n    = ~blank_n & h_act[WIN_CAP] & v_act[WIN_CAP];
    bord_n  = ~blank_n & ~de_n & h_act[WIN_BORD] & v_act[WIN_BORD];
  end

  // Output register stage: aligned with the counter copies.
  always_ff @(posedge clk) begin
    if (rst) begin
      h_count        <= '0;
      v_count        <= '0;
      out_hsync      <= ~out_hs_pol;
      out_vsync      <= ~out_vs_pol;
      out_blank      <= 1'b0;
      out_de         <= 1'b0;
      out_border     <= 1'b0;
      out_border_rgb <= '0;
    end else begin
      h_count        <= hcnt;
      v_count        <= vcnt;
      out_hsync      <= pin_level(out_hs_pol, h_act[WIN_SYNC]);
      out_vsync      <= pin_level(out_vs_pol, v_act[WIN_SYNC]);
      out_blank      <= blank_n;
      out_de         <= de_n;
      out_border     <= bord_n;
      out_border_rgb <= (bord_n && soft_timing) ? border_rgb : '0;
    end
  end
endmodule

// File: rtl/rtg_checker.sv
`timescale 1ns/1ps
module rtg_checker #(
  parameter int HW = 11,
  parameter int VW = 10,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] h_count,
  input logic [VW-1:0] v_count,
  input logic          out_blank,
  input logic          out_de,
  input logic          out_border,
  input logic [CW-1:0] out_border_rgb
);
  p_hstep_r2: assert property (@(posedge clk) disable iff (rst)
    (h_count != '0) |-> (h_count == $past(h_count) + 1'b1));

  p_vhold_r5: assert property (@(posedge clk) disable iff (rst)
    (h_count != '0) |-> $stable(v_count));

  p_de_blank_r9: assert property (@(posedge clk) disable iff (rst)
    out_de |-> !out_blank);

  p_border_excl_r10: assert property (@(posedge clk) disable iff (rst)
    out_border |-> (!out_de && !out_blank));

  p_rgb_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !out_border |-> (out_border_rgb == '0));
endmodule

bind raster_timing_gen rtg_checker #(.HW(HW), .VW(VW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .h_count(h_count), .v_count(v_count),
  .out_blank(out_blank), .out_de(out_de), .out_border(out_border),
  .out_border_rgb(out_border_rgb)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb;
  localparam int HW = 11;
  localparam int VW = 10;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_hsync, in_vsync, in_hs_pol, in_vs_pol, soft_timing;
  logic [HW-4:0] htot_hi;
  logic [1:0]    htot_lo;
  logic [HW-1:0] h_sync_start, h_sync_end, h_blank_start, h_blank_end;
  logic [HW-1:0] h_cap_start, h_cap_end, h_bord_start, h_bord_end;
  logic [VW-1:0] v_sync_start, v_sync_end, v_blank_start, v_blank_end;
  logic [VW-1:0] v_cap_start, v_cap_end, v_bord_start, v_bord_end;
  logic          out_hs_pol, out_vs_pol;
  logic [CW-1:0] border_rgb;
  logic          out_hsync, out_vsync, out_blank, out_de, out_border;
  logic [CW-1:0] out_border_rgb;
  logic [HW-1:0] h_count;
  logic [VW-1:0] v_count;
  logic [VW:0]   v_total;

  int  checks = 0;
  int  errors = 0;
  bit  chk_en = 0;
  bit  vs_en  = 0;
  int  vs_period = 800;
  int  lines = 20;
  int  prev_h = 0;
  bit  done = 0;

  raster_timing_gen u_dut (.*);

  always #4 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit win(input int c, input int s, input int e);
    if (s < e) return (c >= s) && (c < e);
    else if (s > e) return (c >= s) || (c < e);
    else return 1'b0;
  endfunction

  function automatic int eff_total();
    return soft_timing ? ({htot_hi, htot_lo, 1'b0}) : 780;
  endfunction

  // Vertical sync generator: 2-cycle active-high pulse every vs_period cycles.
  initial begin
    int vcyc = 0;
    in_vsync = 1'b0;
    forever begin
      @(negedge clk);
      if (!vs_en) begin
        vcyc = 0;
        in_vsync = 1'b0;
      end else begin
        in_vsync = (vcyc < 2);
        vcyc = (vcyc >= vs_period - 1) ? 0 : vcyc + 1;
      end
    end
  end

  // Per-cycle steady-state checks against the formulas of R2, R3, R7-R11.
  always @(negedge clk) begin
    if (chk_en) begin
      int h, v, tot;
      bit hs, vs, blk, de, bd;
      h   = int'(h_count);
      v   = int'(v_count);
      tot = eff_total();
      if (h != 0) check("R2 h step", h, prev_h + 1);
      else        check("R2 R3 wrap point", prev_h, tot - 1);
      check("R5 line range", v < lines, 1);
      hs  = win(h, h_sync_start, h_sync_end);
      vs  = win(v, v_sync_start, v_sync_end);
      check("R7 R8 hsync", out_hsync, out_hs_pol ? hs : !hs);
      check("R7 R8 vsync", out_vsync, out_vs_pol ? vs : !vs);
      blk = win(h, h_blank_start, h_blank_end) | win(v, v_blank_start, v_blank_end);
      de  = !blk && win(h, h_cap_start, h_cap_end) && win(v, v_cap_start, v_cap_end);
      bd  = !blk && !de && win(h, h_bord_start, h_bord_end) && win(v, v_bord_start, v_bord_end);
      check("R9 R11 blank", out_blank, blk);
      check("R9 R11 de", out_de, de);
      check("R10 border", out_border, bd);
      check("R10 border rgb", out_border_rgb, (bd && soft_timing) ? border_rgb : 0);
    end
    prev_h = int'(h_count);
  end

  task automatic restart_vsync(input int nlines);
    lines = nlines;
    vs_period = nlines * eff_total();
    vs_en = 0;
    repeat (2) @(negedge clk);
    vs_en = 1;
  endtask

  task automatic run_frames();
    repeat (2 * vs_period + 10) @(negedge clk);
    chk_en = 1;
    repeat (vs_period) @(negedge clk);
    chk_en = 0;
    check("R6 measured vertical total", v_total, lines);
  endtask

  task automatic random_windows();
    int tot;
    tot = eff_total();
    h_sync_start  = HW'($urandom_range(0, tot - 1));
    h_sync_end    = HW'($urandom_range(0, tot - 1));
    h_blank_start = HW'($urandom_range(0, tot - 1));
    h_blank_end   = HW'($urandom_range(0, tot - 1));
    h_cap_start   = HW'($urandom_range(0, tot - 1));
    h_cap_end     = HW'($urandom_range(0, tot - 1));
    h_bord_start  = HW'($urandom_range(0, tot - 1));
    h_bord_end    = HW'($urandom_range(0, tot - 1));
    v_sync_start  = VW'($urandom_range(0, lines - 1));
    v_sync_end    = VW'($urandom_range(0, lines - 1));
    v_blank_start = VW'($urandom_range(0, lines - 1));
    v_blank_end   = VW'($urandom_range(0, lines - 1));
    v_cap_start   = VW'($urandom_range(0, lines - 1));
    v_cap_end     = VW'($urandom_range(0, lines - 1));
    v_bord_start  = VW'($urandom_range(0, lines - 1));
    v_bord_end    = VW'($urandom_range(0, lines - 1));
    out_hs_pol    = 1'($urandom_range(0, 1));
    out_vs_pol    = 1'($urandom_range(0, 1));
    border_rgb    = CW'($urandom);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; in_hsync = 0; in_hs_pol = 1; in_vs_pol = 1; soft_timing = 1;
    htot_hi = 8'd5; htot_lo = 2'd0;
    out_hs_pol = 0; out_vs_pol = 1; border_rgb = 24'h3A7C11;
    h_sync_start = 30; h_sync_end = 5;  h_blank_start = 32; h_blank_end = 38;
    h_cap_start  = 4;  h_cap_end  = 28; h_bord_start  = 2;  h_bord_end  = 31;
    v_sync_start = 3;  v_sync_end = 3;  v_blank_start = 16; v_blank_end = 0;
    v_cap_start  = 1;  v_cap_end  = 15; v_bord_start  = 0;  v_bord_end  = 16;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 h_count", h_count, 0);
    check("R1 v_count", v_count, 0);
    check("R1 v_total", v_total, 0);
    check("R1 blank", out_blank, 0);
    check("R1 de", out_de, 0);
    check("R1 border", out_border, 0);
    check("R1 rgb", out_border_rgb, 0);
    check("R1 hsync idle", out_hsync, 1);
    check("R1 vsync idle", out_vsync, 0);
    rst = 0;

    // Directed: wrapping windows (start > end) and an empty one (start == end).
    restart_vsync(20);
    run_frames();

    // Constrained random configurations in software mode.
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      htot_hi = 8'($urandom_range(4, 8));
      htot_lo = 2'($urandom_range(0, 3));
      lines   = $urandom_range(8, 24);
      random_windows();
      restart_vsync(lines);
      run_frames();
    end

    // R3: built-in 780-pixel total, border forced to black.
    @(negedge clk);
    soft_timing = 0;
    lines = 20;
    random_windows();
    restart_vsync(20);
    run_frames();

    // R4: input hsync restart, positive polarity, exact latency.
    @(negedge clk);
    soft_timing = 1; htot_hi = 8'd5; htot_lo = 2'd0;
    restart_vsync(20);
    repeat (100) @(negedge clk);
    while (h_count != 20) @(negedge clk);
    in_hsync = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 no restart before latency (pos)", h_count, 22);
    @(posedge clk);
    @(negedge clk);
    check("R4 restart at zero (pos)", h_count, 0);
    @(negedge clk);
    check("R4 count resumes (pos)", h_count, 1);
    in_hsync = 0;

    // R4: negative polarity; the switch itself may restart once.
    repeat (5) @(negedge clk);
    in_hsync = 1;
    in_hs_pol = 0;
    repeat (60) @(negedge clk);
    while (h_count != 25) @(negedge clk);
    in_hsync = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 no restart before latency (neg)", h_count, 27);
    @(posedge clk);
    @(negedge clk);
    check("R4 restart at zero (neg)", h_count, 0);
    in_hs_pol = 1;
    repeat (5) @(negedge clk);

    // R5: no vsync for more than 1024 lines saturates the line counter.
    htot_hi = 8'd2; htot_lo = 2'd0;
    vs_en = 0;
    repeat (1100 * 16) @(negedge clk);
    check("R5 saturate at 1023", v_count, 1023);
    vs_period = 160;
    vs_en = 1;
    repeat (34) @(negedge clk);
    check("R5 vsync restarts frame", v_count < 2, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule